// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns one serial audio data line into parallel stereo PCM words in the system clock domain. The data line is framed by a bit clock and a channel-select clock. Each channel occupies a fixed 32-bit slot, so the bit clock runs at 64 times the sample rate. The select clock changes level once per channel slot, which makes its frequency equal to the sample rate. Three framing conventions are supported: I2S, left-justified and right-justified. Samples can be 16, 20 or 24 bits wide. Both the framing and the width are set by static configuration pins.

The block can act as the slave of the serial port. In that case the bit clock and the select clock come from outside. They are passed through synchronizer chains together with the data line, and bit-clock rising edges are detected in the system domain. This requires the system clock to run at least four times faster than the bit clock. The block can also act as the master. In that case the system clock is taken as a 256x master clock: the block divides it by 4 to make the bit clock, and divides the bit clock by 64 to make the select clock. It drives both clocks out and samples the data line directly.

Every completed left/right pair appears on two parallel output words together with a one-cycle strobe. Each sample is aligned to the most significant end of the output word, and the unused low bits are zero.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, `sample_valid`, `sample_left`, `sample_right`, `bclk_out` and `lrclk_out` are all zero.
- R2: With `cfg_fmt` = 2'b00 (I2S, the default code), the select clock low marks the left slot, and the sample MSB is taken on the second bit-clock rising edge after a select-clock change.
- R3: With `cfg_fmt` = 2'b01 (left-justified), the select clock high marks the left slot, and the MSB is taken on the first bit-clock rising edge after the change.
- R4: With `cfg_fmt` = 2'b10 (right-justified), the select clock high marks the left slot, and the LSB is the last of the 32 bits in the slot. The MSB therefore sits at slot bit 32 minus the width.
- R5: `cfg_width` selects 16 bits (2'b01), 20 bits (2'b10) or 24 bits (2'b00, the default code). The sample is placed MSB-first in the 24-bit output, and the bits below it are zero.
- R6: Data-line bits that fall outside the sample window of a slot have no effect on the output words.
- R7: `sample_valid` is high for exactly one cycle after each right sample completes. At that point it presents the left sample of the same frame with it. Between strobes both output words hold their values.
- R8: A right slot that is not preceded by a complete left slot since the last strobe produces no strobe.
- R9: With `cfg_master` = 1, `bclk_out` has a period of 4 system clocks and `lrclk_out` a period of 256. `lrclk_out` changes only in the cycle where `bclk_out` falls. Data on `sdata_in` is taken on each `bclk_out` rise.
- R10: With `cfg_master` = 0, `bclk_out` and `lrclk_out` stay low. The external clocks and data are taken through synchronizers, and a bit is sampled on each detected `bclk_in` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the 256x master clock in master mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate serial clocks, 0: accept external clocks |
| cfg_fmt | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified |
| cfg_width | input | 2 | Sample width: 00 24 bits, 01 16 bits, 10 20 bits |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External channel-select clock (slave mode) |
| sdata_in | input | 1 | Serial audio data |
| bclk_out | output | 1 | Generated bit clock (master mode, else low) |
| lrclk_out | output | 1 | Generated channel-select clock (master mode, else low) |
| sample_left | output | OUT_W | Left sample, MSB aligned |
| sample_right | output | OUT_W | Right sample, MSB aligned |
| sample_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The following properties are checked on every cycle:
- the strobe lasts a single cycle;
- the output words stay stable between strobes;
- the low bits below a 16- or 20-bit sample are zero when the strobe fires;
- the clock outputs are quiet in slave mode;
- the generated select clock changes only on a bit-clock fall;
- the reset values hold.

Other behaviour only the bench's scenarios can show:
- that the correct bit of each slot becomes the MSB in every framing;
- that the polarity of the select clock is respected;
- that bits outside the sample window are ignored;
- that a lone right slot is dropped;
- the periods of the generated clocks.

These are shown by streaming random samples with random filler bits and comparing every strobe against a queue of expected pairs.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S  = 2'b00,
      FMT_LJ   = 2'b01,
      FMT_RJ   = 2'b10,
      FMT_RSVD = 2'b11
   } sarx_fmt_e;

   // one bit event presented to the deserializer
   typedef struct packed {
      logic tick;
      logic lr;
      logic data;
   } sarx_bit_t;

   function automatic int unsigned sample_bits(input logic [1:0] code);
      case (code)
         2'b01:   return 16;
         2'b10:   return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/sarx_sync_edge.sv
module sarx_sync_edge
   import sarx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bclk_raw,
   input  logic      lr_raw,
   input  logic      data_raw,
   output sarx_bit_t bit_o
);

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      logic [2:0] q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {bclk_raw, lr_raw, data_raw};
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_st[s-1].q;
         end
      end
   end

   logic [2:0] last_stage;
   logic       bclk_seen_q;

   assign last_stage = g_st[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_seen_q <= 1'b0;
      else        bclk_seen_q <= last_stage[2];
   end

   assign bit_o.tick = last_stage[2] & ~bclk_seen_q;
   assign bit_o.lr   = last_stage[1];
   assign bit_o.data = last_stage[0];

endmodule

// File: rtl/sarx_clkgen.sv
module sarx_clkgen #(
   parameter int DIV       = 4,
   parameter int SLOT_BITS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic bclk_o,
   output logic lrclk_o,
   output logic tick_o
);

   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;
   localparam int FW   = $clog2(2 * SLOT_BITS);

   logic [CW-1:0] div_q;
   logic [FW-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         pos_q <= '0;
      end else if (!run) begin
         div_q <= '0;
         pos_q <= '0;
      end else if (div_q == CW'(DIV - 1)) begin
         div_q <= '0;
         pos_q <= pos_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign bclk_o  = run && (div_q >= CW'(HALF));
   assign lrclk_o = run && pos_q[FW-1];
   assign tick_o  = run && (div_q == CW'(HALF - 1));

endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
   import sarx_pkg::*;
#(
   parameter int SLOT_BITS = 32,
   parameter int OUT_W     = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       fmt_i,
   input  logic [1:0]       width_i,
   input  sarx_bit_t        bit_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);

   localparam int IW = $clog2(SLOT_BITS) + 1;

   sarx_fmt_e        fmt;
   logic             primed_q, locked_q, prev_lr_q, chan_left_q, have_left_q;
   logic [IW-1:0]    idx_q, idx_n, win_lo, win_hi, width_n;
   logic [OUT_W-1:0] shift_q, hold_q, word_n, aligned_n;
   logic             edge_n, locked_n, chan_left_n, left_lvl, in_win, win_end;

   always_comb begin
      fmt      = sarx_fmt_e'(fmt_i);
      width_n  = IW'(sample_bits(width_i));
      left_lvl = (fmt == FMT_LJ) || (fmt == FMT_RJ);
      case (fmt)
         FMT_LJ:  win_lo = '0;
         FMT_RJ:  win_lo = IW'(SLOT_BITS) - width_n;
         default: win_lo = IW'(1);
      endcase
      win_hi      = win_lo + width_n - IW'(1);
      edge_n      = primed_q && (bit_i.lr != prev_lr_q);
      idx_n       = edge_n ? '0 : ((idx_q == '1) ? idx_q : idx_q + 1'b1);
      locked_n    = locked_q | edge_n;
      chan_left_n = edge_n ? (bit_i.lr == left_lvl) : chan_left_q;
      in_win      = locked_n && (idx_n >= win_lo) && (idx_n <= win_hi);
      win_end     = in_win && (idx_n == win_hi);
      word_n      = {shift_q[OUT_W-2:0], bit_i.data};
      aligned_n   = word_n << (OUT_W - int'(width_n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q    <= 1'b0;
         locked_q    <= 1'b0;
         prev_lr_q   <= 1'b0;
         chan_left_q <= 1'b0;
         have_left_q <= 1'b0;
         idx_q       <= '0;
         shift_q     <= '0;
         hold_q      <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (bit_i.tick) begin
            prev_lr_q <= bit_i.lr;
            if (!primed_q) begin
               primed_q <= 1'b1;
            end else begin
               idx_q       <= idx_n;
               locked_q    <= locked_n;
               chan_left_q <= chan_left_n;
               if (in_win) shift_q <= word_n;
               if (win_end) begin
                  if (chan_left_n) begin
                     hold_q      <= aligned_n;
                     have_left_q <= 1'b1;
                  end else if (have_left_q) begin
                     left_o      <= hold_q;
                     right_o     <= aligned_n;
                     valid_o     <= 1'b1;
                     have_left_q <= 1'b0;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sarx_pkg::*;
#(
   parameter int SLOT_BITS   = 32,
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int MCLK_DIV    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_master,
   input  logic [1:0]       cfg_fmt,
   input  logic [1:0]       cfg_width,
   input  logic             bclk_in,
   input  logic             lrclk_in,
   input  logic             sdata_in,
   output logic             bclk_out,
   output logic             lrclk_out,
   output logic [OUT_W-1:0] sample_left,
   output logic [OUT_W-1:0] sample_right,
   output logic             sample_valid
);

   initial begin
      assert (OUT_W >= 24) else $error("OUT_W must hold a 24-bit sample");
      assert (SLOT_BITS > 24 && (SLOT_BITS & (SLOT_BITS - 1)) == 0)
         else $error("SLOT_BITS must be a power of two above 24");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (MCLK_DIV >= 2 && MCLK_DIV % 2 == 0) else $error("MCLK_DIV must be even");
   end

   sarx_bit_t sync_bit, gen_bit, sel_bit;
   logic      gen_bclk, gen_lr, gen_tick;

   sarx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_raw (bclk_in),
      .lr_raw   (lrclk_in),
      .data_raw (sdata_in),
      .bit_o    (sync_bit)
   );

   sarx_clkgen #(.DIV(MCLK_DIV), .SLOT_BITS(SLOT_BITS)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cfg_master),
      .bclk_o  (gen_bclk),
      .lrclk_o (gen_lr),
      .tick_o  (gen_tick)
   );

   always_comb begin
      gen_bit.tick = gen_tick;
      gen_bit.lr   = gen_lr;
      gen_bit.data = sdata_in;
      sel_bit      = cfg_master ? gen_bit : sync_bit;
   end

   assign bclk_out  = gen_bclk;
   assign lrclk_out = gen_lr;

   sarx_deser #(.SLOT_BITS(SLOT_BITS), .OUT_W(OUT_W)) u_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .fmt_i   (cfg_fmt),
      .width_i (cfg_width),
      .bit_i   (sel_bit),
      .left_o  (sample_left),
      .right_o (sample_right),
      .valid_o (sample_valid)
   );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_master,
   input logic [1:0]       cfg_width,
   input logic             bclk_out,
   input logic             lrclk_out,
   input logic [OUT_W-1:0] sample_left,
   input logic [OUT_W-1:0] sample_right,
   input logic             sample_valid
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!sample_valid && sample_left == '0 && sample_right == '0
                  && !bclk_out && !lrclk_out));

   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   assert_words_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |-> ($stable(sample_left) && $stable(sample_right)));

   assert_low_zero16_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && cfg_width == 2'b01)
         |-> (sample_left[OUT_W-17:0] == '0 && sample_right[OUT_W-17:0] == '0));

   assert_low_zero20_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && cfg_width == 2'b10)
         |-> (sample_left[OUT_W-21:0] == '0 && sample_right[OUT_W-21:0] == '0));

   assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_master |-> (!bclk_out && !lrclk_out));

   assert_lr_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_master && $past(cfg_master) && !$stable(lrclk_out)) |-> $fell(bclk_out));

endmodule

bind serial_audio_rx sarx_checker #(.OUT_W(OUT_W)) u_sarx_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_master   (cfg_master),
   .cfg_width    (cfg_width),
   .bclk_out     (bclk_out),
   .lrclk_out    (lrclk_out),
   .sample_left  (sample_left),
   .sample_right (sample_right),
   .sample_valid (sample_valid)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_master;
   logic [1:0]  cfg_fmt, cfg_width;
   logic        bclk_in, lrclk_in, sdata_in;
   logic        bclk_out, lrclk_out;
   logic [23:0] sample_left, sample_right;
   logic        sample_valid;

   always #4 clk = ~clk;

   serial_audio_rx dut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
      .cfg_width(cfg_width), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
      .sdata_in(sdata_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
      .sample_left(sample_left), .sample_right(sample_right),
      .sample_valid(sample_valid)
   );

   int          checks = 0;
   int          errors = 0;
   int          got    = 0;
   string       tag    = "R1";
   logic [47:0] exp_q[$];
   logic        prev_v;
   logic [47:0] last_out;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [47:0] act, input logic [47:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic int wbits(input logic [1:0] code);
      return (code == 2'b01) ? 16 : ((code == 2'b10) ? 20 : 24);
   endfunction

   // bit carried in slot position k for a sample of width w
   function automatic logic bit_for(input int k, input int w, input logic [1:0] fmt,
                                    input logic [23:0] v);
      int lo;
      lo = (fmt == 2'b01) ? 0 : ((fmt == 2'b10) ? 32 - w : 1);
      if (k >= lo && k < lo + w) return v[w - 1 - (k - lo)];
      return logic'($urandom % 2);
   endfunction

   function automatic logic [23:0] align(input logic [23:0] v, input int w);
      return 24'(v << (24 - w));
   endfunction

   // reference comparison on every clock
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_v   = 1'b0;
         last_out = '0;
      end else begin
         if (sample_valid) begin
            check(!prev_v, "R7", "strobe wider than one cycle", 48'(prev_v), 48'd0);
            if (exp_q.size() == 0)
               check(1'b0, "R8", "pair without a preceding left slot",
                     {sample_left, sample_right}, 48'd0);
            else begin
               logic [47:0] e;
               e = exp_q.pop_front();
               check({sample_left, sample_right} == e, tag, "sample pair",
                     {sample_left, sample_right}, e);
            end
            got++;
         end else begin
            check({sample_left, sample_right} == last_out, "R7",
                  "words held between strobes", {sample_left, sample_right}, last_out);
         end
         prev_v   = sample_valid;
         last_out = {sample_left, sample_right};
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", got, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic do_reset(input logic m, input logic [1:0] f, input logic [1:0] w);
      rst_n      = 1'b0;
      cfg_master = m;
      cfg_fmt    = f;
      cfg_width  = w;
      bclk_in    = 1'b0;
      lrclk_in   = 1'b0;
      sdata_in   = 1'b0;
      exp_q.delete();
      repeat (4) @(negedge clk);
      check(!sample_valid && sample_left == 0 && sample_right == 0, "R1",
            "outputs during reset", {sample_left, sample_right}, 48'd0);
      check(!bclk_out && !lrclk_out, "R1", "clock outputs during reset",
            48'({bclk_out, lrclk_out}), 48'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic slave_slot(input logic lvl, input bit real_data, input logic [23:0] v);
      int w;
      w = wbits(cfg_width);
      for (int k = 0; k < 32; k++) begin
         bclk_in  = 1'b0;
         lrclk_in = lvl;
         sdata_in = real_data ? bit_for(k, w, cfg_fmt, v) : logic'($urandom % 2);
         repeat (4) @(negedge clk);
         bclk_in = 1'b1;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic slave_test(input logic [1:0] f, input logic [1:0] wc, input int nf,
                             input string t);
      logic        left_lvl;
      logic [23:0] l, r, mask;
      int          w;
      do_reset(1'b0, f, wc);
      tag      = t;
      w        = wbits(wc);
      mask     = 24'((1 << w) - 1);
      left_lvl = (f != 2'b00);
      slave_slot(~left_lvl, 1'b0, 24'd0);   // lone right slot first: no pair (R8)
      for (int i = 0; i < nf; i++) begin
         l = 24'($urandom) & mask;
         r = 24'($urandom) & mask;
         exp_q.push_back({align(l, w), align(r, w)});
         slave_slot(left_lvl, 1'b1, l);
         slave_slot(~left_lvl, 1'b1, r);
      end
      bclk_in = 1'b0;
      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R7", "every frame delivered", 48'(exp_q.size()), 48'd0);
      check(!bclk_out && !lrclk_out, "R10", "clock outputs quiet in slave mode",
            48'({bclk_out, lrclk_out}), 48'd0);
   endtask

   task automatic master_test(input logic [1:0] f, input logic [1:0] wc, input int nf,
                              input string t);
      logic        left_lvl, pb, plc, plr, primed, in_frame, lr;
      logic [23:0] l, r, mask;
      int          w, k, started, base, cyc, brise, lrise;
      bit          bdone, ldone;
      do_reset(1'b1, f, wc);
      tag      = t;
      w        = wbits(wc);
      mask     = 24'((1 << w) - 1);
      left_lvl = (f != 2'b00);
      pb = 1'b0; plc = 1'b0; plr = 1'b0; primed = 1'b0; in_frame = 1'b0;
      k = 0; started = 0; base = got; cyc = 0; brise = -1; lrise = -1;
      bdone = 1'b0; ldone = 1'b0; l = '0; r = '0;
      while (got - base < nf) begin
         @(negedge clk);
         cyc++;
         if (bclk_out && !pb) begin
            if (brise >= 0 && !bdone) begin
               check(cyc - brise == 4, "R9", "bit clock period", 48'(cyc - brise), 48'd4);
               bdone = 1'b1;
            end
            brise = cyc;
         end
         if (lrclk_out && !plc) begin
            if (lrise >= 0 && !ldone) begin
               check(cyc - lrise == 256, "R9", "select clock period",
                     48'(cyc - lrise), 48'd256);
               ldone = 1'b1;
            end
            lrise = cyc;
         end
         if (!bclk_out && pb) begin
            lr = lrclk_out;
            if (!primed) begin
               primed = 1'b1;
               k = 0;
            end else if (lr != plr) begin
               k = 0;
               if (lr == left_lvl) begin
                  if (started < nf) begin
                     l = 24'($urandom) & mask;
                     r = 24'($urandom) & mask;
                     exp_q.push_back({align(l, w), align(r, w)});
                     in_frame = 1'b1;
                     started++;
                  end else in_frame = 1'b0;
               end
            end else k++;
            plr = lr;
            sdata_in = in_frame ? bit_for(k, w, f, (lr == left_lvl) ? l : r)
                                : logic'($urandom % 2);
         end
         pb  = bclk_out;
         plc = lrclk_out;
      end
      repeat (8) @(negedge clk);
      check(exp_q.size() == 0, "R9", "master frames delivered", 48'(exp_q.size()), 48'd0);
   endtask

   initial begin
      slave_test(2'b00, 2'b00, 3, "R2 R6 R10");
      slave_test(2'b01, 2'b01, 3, "R3 R5 R6");
      slave_test(2'b10, 2'b10, 3, "R4 R5 R6");
      slave_test(2'b10, 2'b01, 2, "R4 R5");
      slave_test(2'b00, 2'b10, 2, "R2 R5");
      master_test(2'b01, 2'b00, 3, "R9 R3");
      master_test(2'b00, 2'b01, 3, "R9 R2 R8");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule